// File: doc/BRIEF.md
# Range-Matched Translation Buffer

This block is a small, fully associative address translation cache for a paged processor. Every slot records an inclusive virtual range (first and last byte of one 4 KiB page), a 20-bit physical page number and a set of protection attributes. A lookup compares the address against every stored range in parallel. It returns the attributes of the lowest-numbered slot whose range contains the address, or a miss, one cycle after it is issued.

Software fills a slot in two steps. An address write names the page and supplies the physical page number. This reuses a slot that already covers that page, or else takes the slot under a round-robin pointer, and it leaves the slot not yet valid. A protection write to the same address then loads the attributes and makes the slot valid. Two purge operations clear slots: one removes the page containing a given address, the other empties the whole buffer. Permission evaluation, table walking and purge broadcast belong to the surrounding logic.

Top module: `range_tlb`

## Requirements
- R1: After reset every slot is empty. An empty slot has begin address all ones and end address zero, so no lookup can match it. Every lookup then misses, and `res_valid` and `err_pulse` are low.
- R2: A lookup accepted on `lk_valid` at one rising edge gives `res_valid` high after that edge for one cycle. At that point exactly one of `res_hit` and `res_miss` is high. When `res_valid` is low, both are low.
- R3: An address write (`wr_op` = 0) sets the slot's begin to the address with bits [11:0] cleared and its end to the address with bits [11:0] set. It loads the physical page number from `wr_data[24:5]`. The slot stays invalid, so a lookup of that page misses until a protection write arrives.
- R4: A protection write (`wr_op` = 1) to a covered address loads the following fields from `wr_data` and marks the slot valid: access id [18:1], U bit 19, PL2 [21:20], PL1 [23:22], access type [26:24], B bit 27, D bit 28, T bit 29. A later lookup hit returns these fields and the physical page number.
- R5: A protection write to an address that no slot covers changes nothing and raises `err_pulse` for exactly one cycle. `err_pulse` is low after every other operation.
- R6: An address write first clears every slot covering the address and reuses the lowest such slot without moving the replacement pointer. If no slot covers the address, it takes the slot at the pointer. The pointer starts at 0 and steps by one per such write, wrapping from the last slot to 0.
- R7: A page purge (`wr_op` = 2) empties the lowest slot covering the address only if that slot is valid. Other slots, and a covering slot that is still invalid, are left intact.
- R8: A purge-all (`wr_op` = 3) empties every slot in one cycle and leaves the replacement pointer where it was.
- R9: A lookup issued in the same cycle as a write sees the contents from before that write.
- R10: Range matching is inclusive: the first and last byte of a stored page hit, and the bytes just outside it miss.
- R11: `wr_ready` is high in every cycle, so one write per cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup virtual address |
| wr_valid | input | 1 | Write/purge request |
| wr_ready | output | 1 | Write channel ready |
| wr_op | input | 2 | 0 address write, 1 protection write, 2 page purge, 3 purge-all |
| wr_addr | input | 32 | Virtual address for the write or purge |
| wr_data | input | 32 | Data word for address and protection writes |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup found a valid slot |
| res_miss | output | 1 | Lookup found no valid slot |
| res_index | output | 4 | Slot number of the hit |
| res_ppn | output | 20 | Physical page number of the hit |
| res_acc_id | output | 18 | Access id of the hit |
| res_u | output | 1 | U attribute |
| res_pl2 | output | 2 | PL2 attribute |
| res_pl1 | output | 2 | PL1 attribute |
| res_ar | output | 3 | Access type attribute |
| res_b | output | 1 | B attribute |
| res_d | output | 1 | D attribute |
| res_t | output | 1 | T attribute |
| err_pulse | output | 1 | Protection write found no slot |

## Verification
The assertions check the result handshake on every cycle: the one-cycle timing of `res_valid`, the exclusive hit/miss pair, and that `err_pulse` only follows a protection write. They also check that a lookup of a freshly addressed page, or any lookup just after a purge-all, misses. Field placement, round-robin order and its wrap, slot reuse, the selective page purge and the boundary bytes depend on a chosen sequence of writes, so only the directed scenarios show them.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

    typedef enum logic [1:0] {
        OP_INSERT    = 2'd0,
        OP_PROT      = 2'd1,
        OP_PURGE     = 2'd2,
        OP_PURGE_ALL = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic [17:0] acc_id;
        logic        u;
        logic [1:0]  pl2;
        logic [1:0]  pl1;
        logic [2:0]  ar;
        logic        b;
        logic        d;
        logic        t;
    } prot_t;

    localparam int PPN_LSB = 5;

    function automatic prot_t unpack_prot(input logic [31:0] w);
        prot_t p;
        p.acc_id = w[18:1];
        p.u      = w[19];
        p.pl2    = w[21:20];
        p.pl1    = w[23:22];
        p.ar     = w[26:24];
        p.b      = w[27];
        p.d      = w[28];
        p.t      = w[29];
        return p;
    endfunction

endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32
) (
    input  logic [ENTRIES-1:0][VA_W-1:0] beg,
    input  logic [ENTRIES-1:0][VA_W-1:0] fin,
    input  logic [VA_W-1:0]              addr,
    output logic [ENTRIES-1:0]           hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = (beg[i] <= addr) && (addr <= fin[i]);
    end
endmodule

// File: rtl/range_tlb_first.sv
module range_tlb_first #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
    import range_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PG_BITS = 12,
    parameter int PPN_W   = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [VA_W-1:0]            lk_addr,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic [1:0]                 wr_op,
    input  logic [VA_W-1:0]            wr_addr,
    input  logic [31:0]                wr_data,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic                       res_miss,
    output logic [$clog2(ENTRIES)-1:0] res_index,
    output logic [PPN_W-1:0]           res_ppn,
    output logic [17:0]                res_acc_id,
    output logic                       res_u,
    output logic [1:0]                 res_pl2,
    output logic [1:0]                 res_pl1,
    output logic [2:0]                 res_ar,
    output logic                       res_b,
    output logic                       res_d,
    output logic                       res_t,
    output logic                       err_pulse
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - PG_BITS;

    typedef struct packed {
        logic [ENTRIES-1:0][VA_W-1:0]  beg;
        logic [ENTRIES-1:0][VA_W-1:0]  fin;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        prot_t [ENTRIES-1:0]           prot;
        logic [ENTRIES-1:0]            vld;
        logic [IDX_W-1:0]              rr;
        logic                          res_valid;
        logic                          res_hit;
        logic [IDX_W-1:0]              res_idx;
        logic [PPN_W-1:0]              res_ppn;
        prot_t                         res_prot;
        logic                          err;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] lk_hits, wr_hits;
    logic               lk_any, wr_any;
    logic [IDX_W-1:0]   lk_idx, wr_idx, ins_idx;
    logic               lk_good;
    logic               unused_data;

    assign unused_data = ^{wr_data[31:PPN_LSB+PPN_W], wr_data[0]};

    range_tlb_match #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_lk_match (
        .beg(s_q.beg), .fin(s_q.fin), .addr(lk_addr), .hit(lk_hits)
    );
    range_tlb_match #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_wr_match (
        .beg(s_q.beg), .fin(s_q.fin), .addr(wr_addr), .hit(wr_hits)
    );
    range_tlb_first #(.ENTRIES(ENTRIES)) u_lk_first (
        .req(lk_hits), .any(lk_any), .idx(lk_idx)
    );
    range_tlb_first #(.ENTRIES(ENTRIES)) u_wr_first (
        .req(wr_hits), .any(wr_any), .idx(wr_idx)
    );

    always_comb begin
        s_d     = s_q;
        ins_idx = wr_any ? wr_idx : s_q.rr;
        lk_good = lk_any && s_q.vld[lk_idx];

        // lookup result, taken from the pre-write contents (R9)
        s_d.res_valid = lk_valid;
        s_d.res_hit   = lk_valid && lk_good;
        s_d.res_idx   = lk_good ? lk_idx : '0;
        s_d.res_ppn   = lk_good ? s_q.ppn[lk_idx] : '0;
        s_d.res_prot  = lk_good ? s_q.prot[lk_idx] : '0;
        s_d.err       = 1'b0;

        if (wr_valid) begin
            case (wr_op)
                OP_INSERT: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (wr_hits[i]) begin
                            s_d.beg[i]  = '1;
                            s_d.fin[i]  = '0;
                            s_d.ppn[i]  = '0;
                            s_d.prot[i] = '0;
                            s_d.vld[i]  = 1'b0;
                        end
                    end
                    if (!wr_any) begin
                        s_d.rr = (s_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.rr + 1'b1;
                    end
                    s_d.beg[ins_idx]  = {wr_addr[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
                    s_d.fin[ins_idx]  = {wr_addr[VA_W-1:PG_BITS], {PG_BITS{1'b1}}};
                    s_d.ppn[ins_idx]  = wr_data[PPN_LSB +: PPN_W];
                    s_d.prot[ins_idx] = '0;
                    s_d.vld[ins_idx]  = 1'b0;
                end
                OP_PROT: begin
                    if (wr_any) begin
                        s_d.prot[wr_idx] = unpack_prot(wr_data);
                        s_d.vld[wr_idx]  = 1'b1;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
                OP_PURGE: begin
                    if (wr_any && s_q.vld[wr_idx]) begin
                        s_d.beg[wr_idx]  = '1;
                        s_d.fin[wr_idx]  = '0;
                        s_d.ppn[wr_idx]  = '0;
                        s_d.prot[wr_idx] = '0;
                        s_d.vld[wr_idx]  = 1'b0;
                    end
                end
                default: begin
                    s_d.beg  = '1;
                    s_d.fin  = '0;
                    s_d.ppn  = '0;
                    s_d.prot = '0;
                    s_d.vld  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.beg <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ready   = 1'b1;
    assign res_valid  = s_q.res_valid;
    assign res_hit    = s_q.res_hit;
    assign res_miss   = s_q.res_valid && !s_q.res_hit;
    assign res_index  = s_q.res_idx;
    assign res_ppn    = s_q.res_ppn;
    assign res_acc_id = s_q.res_prot.acc_id;
    assign res_u      = s_q.res_prot.u;
    assign res_pl2    = s_q.res_prot.pl2;
    assign res_pl1    = s_q.res_prot.pl1;
    assign res_ar     = s_q.res_prot.ar;
    assign res_b      = s_q.res_prot.b;
    assign res_d      = s_q.res_prot.d;
    assign res_t      = s_q.res_prot.t;
    assign err_pulse  = s_q.err;

    if (VPN_W < 1) begin : g_bad_cfg
        initial $error("page offset wider than the address");
    end

endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk
    import range_tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PG_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_addr,
    input logic            wr_valid,
    input logic [1:0]      wr_op,
    input logic [VA_W-1:0] wr_addr,
    input logic            res_valid,
    input logic            res_hit,
    input logic            res_miss,
    input logic            err_pulse
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_hit_miss_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));

    assert_idle_flags_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_miss));

    assert_err_only_on_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_op == OP_PROT) |=> !err_pulse);

    assert_fresh_entry_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_op == OP_INSERT) ##1
        (lk_valid && lk_addr[VA_W-1:PG_BITS] == $past(wr_addr[VA_W-1:PG_BITS]))
        |=> res_miss);

    assert_purge_all_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_op == OP_PURGE_ALL) ##1 lk_valid |=> res_miss);
endmodule

bind range_tlb range_tlb_chk #(.VA_W(VA_W), .PG_BITS(PG_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wr_valid(wr_valid), .wr_op(wr_op), .wr_addr(wr_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .err_pulse(err_pulse)
);

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [1:0]  wr_op = '0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        res_valid, res_hit, res_miss;
    logic [3:0]  res_index;
    logic [19:0] res_ppn;
    logic [17:0] res_acc_id;
    logic        res_u, res_b, res_d, res_t, err_pulse;
    logic [1:0]  res_pl2, res_pl1;
    logic [2:0]  res_ar;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    range_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_op(wr_op),
        .wr_addr(wr_addr), .wr_data(wr_data), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_index(res_index),
        .res_ppn(res_ppn), .res_acc_id(res_acc_id), .res_u(res_u),
        .res_pl2(res_pl2), .res_pl1(res_pl1), .res_ar(res_ar), .res_b(res_b),
        .res_d(res_d), .res_t(res_t), .err_pulse(err_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_prot(input logic [17:0] acc, input logic u,
            input logic [1:0] pl2, input logic [1:0] pl1, input logic [2:0] ar,
            input logic b, input logic d, input logic t);
        return {2'b00, t, d, b, ar, pl1, pl2, u, acc, 1'b0};
    endfunction

    task automatic do_write(input logic [1:0] op, input logic [31:0] a, input logic [31:0] dat);
        @(negedge clk);
        wr_valid = 1'b1; wr_op = op; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic add_page(input logic [31:0] a, input logic [19:0] ppn);
        do_write(2'd0, a, {7'd0, ppn, 5'd0});
        do_write(2'd1, a, mk_prot(18'h00123, 1'b0, 2'd0, 2'd3, 3'd3, 1'b0, 1'b1, 1'b0));
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] a,
            input logic [3:0] idx, input logic [19:0] ppn);
        do_lookup(a);
        chk({tag, " hit"}, {res_valid, res_hit, res_miss}, 3'b110);
        chk({tag, " index"}, res_index, idx);
        chk({tag, " ppn"}, res_ppn, ppn);
    endtask

    task automatic expect_miss(input string tag, input logic [31:0] a);
        do_lookup(a);
        chk({tag, " miss"}, {res_valid, res_hit, res_miss}, 3'b101);
    endtask

    task automatic t_reset;
        chk("R1 res_valid after reset", res_valid, 1'b0);
        chk("R1 err after reset", err_pulse, 1'b0);
        chk("R11 ready", wr_ready, 1'b1);
        expect_miss("R1 addr zero", 32'h0000_0000);
        expect_miss("R1 addr ones", 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R2 result drops", {res_valid, res_hit, res_miss}, 3'b000);
    endtask

    task automatic t_insert_prot;
        do_write(2'd0, 32'h1234_5678, {7'd0, 20'hABCDE, 5'd0});
        expect_miss("R3 invalid before prot", 32'h1234_5000);
        do_write(2'd1, 32'h1234_5FFF,
                 mk_prot(18'h2AAAB, 1'b1, 2'd2, 2'd1, 3'd5, 1'b1, 1'b0, 1'b1));
        chk("R5 no err on good prot", err_pulse, 1'b0);
        expect_hit("R4 after prot", 32'h1234_5ABC, 4'd0, 20'hABCDE);
        chk("R4 fields", {res_acc_id, res_u, res_pl2, res_pl1, res_ar, res_b, res_d, res_t},
            {18'h2AAAB, 1'b1, 2'd2, 2'd1, 3'd5, 1'b1, 1'b0, 1'b1});
    endtask

    task automatic t_boundaries;
        expect_hit("R10 first byte", 32'h1234_5000, 4'd0, 20'hABCDE);
        expect_hit("R10 last byte", 32'h1234_5FFF, 4'd0, 20'hABCDE);
        expect_miss("R10 next page", 32'h1234_6000);
        expect_miss("R10 previous page", 32'h1234_4FFF);
    endtask

    task automatic t_prot_orphan;
        do_write(2'd1, 32'h7000_0000, mk_prot(18'h1, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 1'b1, 1'b0));
        chk("R5 err pulse", err_pulse, 1'b1);
        @(negedge clk);
        chk("R5 err one cycle", err_pulse, 1'b0);
        expect_miss("R5 orphan ignored", 32'h7000_0000);
        expect_hit("R5 other slot kept", 32'h1234_5000, 4'd0, 20'hABCDE);
        chk("R5 other fields kept", res_acc_id, 18'h2AAAB);
    endtask

    task automatic t_purge_page;
        add_page(32'h2000_0000, 20'h11111);
        expect_hit("R7 setup", 32'h2000_0000, 4'd1, 20'h11111);
        do_write(2'd2, 32'h2000_0010, 32'h0);
        expect_miss("R7 purged page", 32'h2000_0000);
        expect_hit("R7 neighbour kept", 32'h1234_5000, 4'd0, 20'hABCDE);
        do_write(2'd0, 32'h3000_0000, {7'd0, 20'h33333, 5'd0});
        do_write(2'd2, 32'h3000_0000, 32'h0);
        do_write(2'd1, 32'h3000_0000, mk_prot(18'h5, 1'b0, 2'd0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0));
        chk("R7 invalid slot survived purge", err_pulse, 1'b0);
        expect_hit("R7 invalid slot survived purge", 32'h3000_0000, 4'd2, 20'h33333);
    endtask

    task automatic t_reuse;
        do_write(2'd0, 32'h1234_5800, {7'd0, 20'h00042, 5'd0});
        expect_miss("R6 reused slot invalid", 32'h1234_5000);
        do_write(2'd1, 32'h1234_5000, mk_prot(18'h7, 1'b0, 2'd0, 2'd0, 3'd2, 1'b0, 1'b1, 1'b0));
        expect_hit("R6 reuse same slot", 32'h1234_5000, 4'd0, 20'h00042);
        add_page(32'h4000_0000, 20'h44444);
        expect_hit("R6 pointer not moved by reuse", 32'h4000_0000, 4'd3, 20'h44444);
    endtask

    task automatic t_round_robin;
        for (int k = 0; k < 12; k++) begin
            add_page(32'h5000_0000 + (k << 12), 20'h50000 + 20'(k));
        end
        expect_hit("R6 last slot", 32'h5000_B000, 4'd15, 20'h5000B);
        expect_hit("R6 mid slot", 32'h5000_0000, 4'd4, 20'h50000);
        add_page(32'h6000_0000, 20'h66666);
        expect_hit("R6 wrap to slot 0", 32'h6000_0000, 4'd0, 20'h66666);
        expect_miss("R6 evicted page", 32'h1234_5000);
    endtask

    task automatic t_same_cycle;
        do_write(2'd0, 32'h7000_1000, {7'd0, 20'h77777, 5'd0});
        @(negedge clk);
        wr_valid = 1'b1; wr_op = 2'd1; wr_addr = 32'h7000_1000;
        wr_data = mk_prot(18'h9, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 1'b1, 1'b0);
        lk_valid = 1'b1; lk_addr = 32'h7000_1000;
        @(negedge clk);
        wr_valid = 1'b0; lk_valid = 1'b0;
        chk("R9 lookup sees pre-write", {res_valid, res_hit, res_miss}, 3'b101);
        expect_hit("R9 visible afterwards", 32'h7000_1000, 4'd1, 20'h77777);
    endtask

    task automatic t_purge_all;
        @(negedge clk);
        wr_valid = 1'b1; wr_op = 2'd3; wr_addr = '0; wr_data = '0;
        lk_valid = 1'b1; lk_addr = 32'h6000_0000;
        @(negedge clk);
        wr_valid = 1'b0; lk_valid = 1'b0;
        chk("R9 hit before purge-all", {res_valid, res_hit, res_miss}, 3'b110);
        expect_miss("R8 slot 0 gone", 32'h6000_0000);
        expect_miss("R8 slot 1 gone", 32'h7000_1000);
        expect_miss("R8 slot 15 gone", 32'h5000_B000);
        add_page(32'h8000_0000, 20'h88888);
        expect_hit("R8 pointer kept", 32'h8000_0000, 4'd2, 20'h88888);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_insert_prot();
        t_boundaries();
        t_prot_orphan();
        t_purge_page();
        t_reuse();
        t_round_robin();
        t_same_cycle();
        t_purge_all();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule